// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside an 8-bit microcontroller core and picks which of nine interrupt sources the core should take next. Each source has an enable bit and a two-bit priority level. There is also one global enable that silences every source at once. The block tracks which priority levels have a handler running, so that a handler is interrupted only by a request at a strictly higher level. Level 3, the top level, is never interrupted.

When a source is allowed to run, the block registers a request together with that source's fixed vector address and its level. It holds all three steady until the core acknowledges. A return pulse from the core closes the innermost running handler. Configuration is written through a byte-wide port with a write strobe and an address.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous reset, `int_req` is 0 and `svc_levels` is 0. All enables, both priority vectors and the global enable are cleared, so no source can raise a request until it is configured.
- R2: A write with `cfg_we`=1 updates one configuration byte at the next edge. The addresses are:
  - 0 holds enables for sources 0..7.
  - 1 bit 0 holds the enable for source 8.
  - 4 and 5 hold the low priority bits, laid out the same way.
  - 8 and 9 hold the high priority bits, laid out the same way.
  - 12 bit 0 holds the global enable.
- R3: A source whose enable bit is 0 never causes a request, whatever its `irq_src` line does.
- R4: While the global enable is 0, no new request is raised. A request already held is withdrawn at the first edge after the global enable reads 0, unless it is acknowledged in that same cycle.
- R5: The level of source s is {high bit s, low bit s}, from 0 (lowest) to 3 (highest). Among eligible pending sources, the one with the highest level wins, and `int_lvl` reports that level.
- R6: Among eligible pending sources at the same level, the lowest source index wins. The sources are indexed 0 INT0, 1 Timer0, 2 INT1, 3 Timer1, 4 PCA, 5 UART, 6 Timer2, 7 ADC, 8 SPI.
- R7: `int_vec` carries the source's fixed vector address:
  - INT0 0003h, Timer0 000Bh, INT1 0013h, Timer1 001Bh
  - PCA 0033h, UART 0023h, Timer2 002Bh, ADC 0043h, SPI 0053h
- R8: When `int_req` is 0 and an eligible source is pending, `int_req` rises at the next edge. `int_vec` and `int_lvl` then stay unchanged until acknowledge, even if the sources change.
- R9: When `int_ack` is high while `int_req` is 1, `int_req` is 0 after the next edge, and the `svc_levels` bit for `int_lvl` is set. `int_ack` while `int_req` is 0 has no effect.
- R10: While `svc_levels` is non-zero, a pending source is eligible only if its level is strictly above the highest set bit of `svc_levels`. With bit 3 set, nothing is eligible.
- R11: A pulse on `int_ret` clears the highest set bit of `svc_levels` at the next edge. With `svc_levels` at 0, it has no effect.
- R12: When `int_ret` and an accepted acknowledge fall in the same cycle, the highest set bit is cleared first, and then the bit for the acknowledged level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 9 | Request flags, one per source, indexed as in R6 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| int_ack | input | 1 | Core accepts the presented request |
| int_ret | input | 1 | Core returns from the innermost handler |
| int_req | output | 1 | Registered request to the core |
| int_vec | output | 16 | Vector address of the presented source |
| int_lvl | output | 2 | Level of the presented source |
| svc_levels | output | 4 | In-service bit per level |

## Verification
The overlap that matters is an acknowledge and a return landing in the same cycle. In that cycle the in-service vector loses its top bit and gains the acknowledged level's bit. A directed case builds a level-0 handler in service, presents a level-1 request, and pulses both strobes together. The expected vector is 0010b, not 0011b.

The random phase fires returns independently of acknowledges, so the overlap also recurs with every mix of nesting depth. Each cycle is judged against a bench model of the ordering rule. A second overlap is also covered: the global enable is cleared while a request is held, both with and without a simultaneous acknowledge.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int SRC_N = 9;
  localparam int LVL_W = 2;
  localparam int VEC_W = 16;

  // configuration byte map (region bases)
  localparam int CFG_EN_BASE  = 0;
  localparam int CFG_LO_BASE  = 4;
  localparam int CFG_HI_BASE  = 8;
  localparam int CFG_GIE_ADDR = 12;

  // fixed vector per polling index
  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    logic [VEC_W-1:0] v;
    case (idx)
      0:       v = VEC_W'(16'h0003);
      1:       v = VEC_W'(16'h000B);
      2:       v = VEC_W'(16'h0013);
      3:       v = VEC_W'(16'h001B);
      4:       v = VEC_W'(16'h0033);
      5:       v = VEC_W'(16'h0023);
      6:       v = VEC_W'(16'h002B);
      7:       v = VEC_W'(16'h0043);
      8:       v = VEC_W'(16'h0053);
      default: v = VEC_W'(3 + 8 * idx);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_nest_pkg::*;
#(
  parameter int N_SRC  = SRC_N,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [N_SRC-1:0]  en,
  output logic [N_SRC-1:0]  plo,
  output logic [N_SRC-1:0]  phi,
  output logic              gie
);

  int addr_i;
  assign addr_i = int'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      plo <= '0;
      phi <= '0;
      gie <= 1'b0;
    end else if (we) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (addr_i == CFG_EN_BASE + i / 8) en[i]  <= wdata[i % 8];
        if (addr_i == CFG_LO_BASE + i / 8) plo[i] <= wdata[i % 8];
        if (addr_i == CFG_HI_BASE + i / 8) phi[i] <= wdata[i % 8];
      end
      if (addr_i == CFG_GIE_ADDR) gie <= wdata[0];
    end
  end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int LVL_W = 2,
  localparam int LVL_N = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic             ret,
  output logic [LVL_N-1:0] svc,
  output logic             busy,
  output logic [LVL_W-1:0] cur_lvl
);

  logic [LVL_N-1:0] svc_nx;

  always_comb begin
    busy    = 1'b0;
    cur_lvl = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (svc[l]) begin
        busy    = 1'b1;
        cur_lvl = LVL_W'(l);
      end
    end
  end

  // return clears innermost level first, then acknowledge adds its level
  always_comb begin
    svc_nx = svc;
    if (ret && busy) svc_nx[cur_lvl] = 1'b0;
    if (ack)         svc_nx[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) svc <= '0;
    else     svc <= svc_nx;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 9,
  parameter int LVL_W = 2,
  localparam int LVL_N = 1 << LVL_W,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] plo,
  input  logic [N_SRC-1:0] phi,
  input  logic             busy,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl
);

  logic [LVL_W-1:0] src_lvl [N_SRC];
  logic [LVL_N-1:0] lvl_hit;

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign src_lvl[s] = LVL_W'({phi[s], plo[s]});
    end
    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
      logic [N_SRC-1:0] at_lvl;
      for (genvar s = 0; s < N_SRC; s++) begin : g_m
        assign at_lvl[s] = pend[s] && (src_lvl[s] == LVL_W'(l));
      end
      assign lvl_hit[l] = |at_lvl;
    end
  endgenerate

  // stage 1: highest eligible level
  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    for (int l = LVL_N - 1; l >= 0; l--) begin
      if (!win_valid && lvl_hit[l] && (!busy || LVL_W'(l) > cur_lvl)) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(l);
      end
    end
  end

  // stage 2: first source in polling order at that level
  always_comb begin
    win_idx = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (pend[s] && src_lvl[s] == win_lvl) win_idx = IDX_W'(s);
    end
  end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int N_SRC  = SRC_N,
  parameter int PLVL_W = LVL_W,
  parameter int VADR_W = VEC_W,
  parameter int ADDR_W = 4,
  localparam int LVL_N = 1 << PLVL_W,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              int_ack,
  input  logic              int_ret,
  output logic              int_req,
  output logic [VADR_W-1:0] int_vec,
  output logic [PLVL_W-1:0] int_lvl,
  output logic [LVL_N-1:0]  svc_levels
);

  logic [N_SRC-1:0]  en, plo, phi, pend;
  logic              gie;
  logic              busy;
  logic [PLVL_W-1:0] cur_lvl;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [PLVL_W-1:0] win_lvl;
  logic              ack_ok;

  irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .plo(plo), .phi(phi), .gie(gie)
  );

  assign pend   = irq_src & en & {N_SRC{gie}};
  assign ack_ok = int_ack && int_req;

  irq_svc_track #(.LVL_W(PLVL_W)) u_svc (
    .clk(clk), .rst(rst), .ack(ack_ok), .ack_lvl(int_lvl), .ret(int_ret),
    .svc(svc_levels), .busy(busy), .cur_lvl(cur_lvl)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(PLVL_W)) u_arb (
    .pend(pend), .plo(plo), .phi(phi), .busy(busy), .cur_lvl(cur_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req <= 1'b0;
      int_vec <= '0;
      int_lvl <= '0;
    end else if (int_req) begin
      if (int_ack || !gie) int_req <= 1'b0;
    end else if (win_valid) begin
      int_req <= 1'b1;
      int_vec <= VADR_W'(src_vector(int'(win_idx)));
      int_lvl <= win_lvl;
    end
  end

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int PLVL_W = 2,
  parameter int VADR_W = 16,
  localparam int LVL_N = 1 << PLVL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              int_ack,
  input logic              int_ret,
  input logic              int_req,
  input logic [VADR_W-1:0] int_vec,
  input logic [PLVL_W-1:0] int_lvl,
  input logic [LVL_N-1:0]  svc_levels
);

  function automatic int top_lvl(input logic [LVL_N-1:0] v);
    int t = -1;
    for (int l = 0; l < LVL_N; l++) if (v[l]) t = l;
    return t;
  endfunction

  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (int_req && !int_ack) |=> (!int_req || ($stable(int_vec) && $stable(int_lvl))));

  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_ack) |=> !int_req);

  assert_ack_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_ack) |=> ((svc_levels >> $past(int_lvl)) & 1) == 1);

  assert_top_locks_R10: assert property (@(posedge clk) disable iff (rst)
    svc_levels[LVL_N-1] |-> !int_req);

  assert_strict_preempt_R10: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (int'(int_lvl) > top_lvl(svc_levels)));

  assert_ret_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (int_ret && !(int_req && int_ack) && svc_levels == '0) |=> svc_levels == '0);

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.PLVL_W(PLVL_W), .VADR_W(VADR_W)) u_chk (
  .clk(clk), .rst(rst), .int_ack(int_ack), .int_ret(int_ret), .int_req(int_req),
  .int_vec(int_vec), .int_lvl(int_lvl), .svc_levels(svc_levels)
);

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  irq_src;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        int_ack, int_ret;
  logic        int_req;
  logic [15:0] int_vec;
  logic [1:0]  int_lvl;
  logic [3:0]  svc_levels;

  always #2.5 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_src(irq_src), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .int_ack(int_ack), .int_ret(int_ret), .int_req(int_req),
    .int_vec(int_vec), .int_lvl(int_lvl), .svc_levels(svc_levels)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string tag = "R1";

  // bench model state
  logic [8:0]  m_en, m_lo, m_hi;
  logic        m_gie;
  logic [3:0]  m_svc;
  logic        m_req;
  logic [15:0] m_vec;
  logic [1:0]  m_lvl;

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return 16'h0003; 1: return 16'h000B; 2: return 16'h0013;
      3: return 16'h001B; 4: return 16'h0033; 5: return 16'h0023;
      6: return 16'h002B; 7: return 16'h0043; default: return 16'h0053;
    endcase
  endfunction

  function automatic int hi_bit(input logic [3:0] v);
    int t = -1;
    for (int l = 0; l < 4; l++) if (v[l]) t = l;
    return t;
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", r, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_lo = '0; m_hi = '0; m_gie = 0;
    m_svc = '0; m_req = 0; m_vec = '0; m_lvl = '0;
  endtask

  task automatic model_edge();
    logic [8:0] pend;
    int cur, best, bl, lv, top;
    logic [3:0] nsvc;
    pend = irq_src & m_en & {9{m_gie}};
    cur = hi_bit(m_svc);
    best = -1; bl = -1;
    for (int s = 0; s < 9; s++) begin
      lv = {m_hi[s], m_lo[s]};
      if (pend[s] && lv > cur && lv > bl) begin best = s; bl = lv; end
    end
    nsvc = m_svc;
    top = hi_bit(m_svc);
    if (int_ret && top >= 0) nsvc[top] = 1'b0;
    if (int_ack && m_req) nsvc[m_lvl] = 1'b1;
    if (m_req) begin
      if (int_ack || !m_gie) m_req = 0;
    end else if (best >= 0) begin
      m_req = 1; m_vec = exp_vec(best); m_lvl = 2'(bl);
    end
    m_svc = nsvc;
    if (cfg_we) begin
      for (int i = 0; i < 9; i++) begin
        if (int'(cfg_addr) == 0 + i / 8) m_en[i] = cfg_wdata[i % 8];
        if (int'(cfg_addr) == 4 + i / 8) m_lo[i] = cfg_wdata[i % 8];
        if (int'(cfg_addr) == 8 + i / 8) m_hi[i] = cfg_wdata[i % 8];
      end
      if (cfg_addr == 4'd12) m_gie = cfg_wdata[0];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    chk({tag, " req"}, 32'(int_req), 32'(m_req));
    chk({tag, " svc"}, 32'(svc_levels), 32'(m_svc));
    if (m_req) begin
      chk({tag, " vec"}, 32'(int_vec), 32'(m_vec));
      chk({tag, " lvl"}, 32'(int_lvl), 32'(m_lvl));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic set_en(input logic [8:0] v);  wr(0, v[7:0]); wr(1, {7'd0, v[8]}); endtask
  task automatic set_lo(input logic [8:0] v);  wr(4, v[7:0]); wr(5, {7'd0, v[8]}); endtask
  task automatic set_hi(input logic [8:0] v);  wr(8, v[7:0]); wr(9, {7'd0, v[8]}); endtask
  task automatic set_gie(input logic g);       wr(12, {7'd0, g}); endtask
  task automatic ack();  int_ack = 1; tick(); int_ack = 0; endtask
  task automatic ret();  int_ret = 1; tick(); int_ret = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    irq_src = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    int_ack = 0; int_ret = 0;
    rst = 1; tag = "R1";
    tick(); tick();
    rst = 0;
    chk("R1 reset req", 32'(int_req), 0);
    chk("R1 reset svc", 32'(svc_levels), 0);
    irq_src = 9'h1FF;
    repeat (4) tick();
    chk("R1 unconfigured no req", 32'(int_req), 0);

    // R2/R3: only INT1 enabled
    tag = "R3";
    irq_src = '0;
    set_gie(1); set_en(9'b000000100);
    irq_src = 9'b000000101; tick();
    chk("R3 only enabled source", 32'(int_vec), 32'h0013);
    chk("R2 config took effect", 32'(int_req), 1);
    ack(); irq_src = '0; ret(); tick();

    // R6: same-level tie
    tag = "R6";
    set_en(9'h1FF);
    irq_src = 9'b000000110; tick();
    chk("R6 polling Timer0 over INT1", 32'(int_vec), 32'h000B);
    // R8: vector holds though sources change
    tag = "R8";
    irq_src = 9'b000000001; tick(); tick();
    chk("R8 vector stable", 32'(int_vec), 32'h000B);
    tag = "R9";
    ack();
    chk("R9 req drop", 32'(int_req), 0);
    chk("R9 svc set", 32'(svc_levels), 32'b0001);
    irq_src = '0; int_ack = 1; tick(); int_ack = 0;
    chk("R9 stray ack ignored", 32'(svc_levels), 32'b0001);
    ret();
    chk("R11 ret clears", 32'(svc_levels), 0);
    tag = "R11"; ret();
    chk("R11 ret idle", 32'(svc_levels), 0);

    // R5: level wins over polling order
    tag = "R5";
    set_hi(9'b100000000);
    irq_src = 9'b100000001; tick();
    chk("R5 SPI at level 2", 32'(int_vec), 32'h0053);
    chk("R5 level", 32'(int_lvl), 2);
    ack();
    // R10: lower/equal waits, higher preempts
    tag = "R10";
    irq_src = 9'b000000001; tick(); tick();
    chk("R10 lower waits", 32'(int_req), 0);
    set_hi(9'b100000010);   // Timer0 level 2 = equal
    irq_src = 9'b000000010; tick(); tick();
    chk("R10 equal waits", 32'(int_req), 0);
    set_lo(9'b000000001); set_hi(9'b100000011); // INT0 level 3
    irq_src = 9'b000000011; tick();
    chk("R10 higher preempts", 32'(int_vec), 32'h0003);
    ack();
    chk("R10 nested svc", 32'(svc_levels), 32'b1100);
    set_lo(9'b000000011);   // Timer0 also level 3
    repeat (3) tick();
    chk("R10 level3 locked", 32'(int_req), 0);
    irq_src = '0;
    tag = "R11"; ret();
    chk("R11 clears top", 32'(svc_levels), 32'b0100);
    ret();
    chk("R11 clears next", 32'(svc_levels), 0);

    // R12: ack and ret together
    tag = "R12";
    set_lo(9'b000001000); set_hi('0);  // Timer1 level 1, others level 0
    irq_src = 9'b000000100; tick(); ack();
    irq_src = 9'b000001000; tick();
    chk("R12 lvl1 request", 32'(int_lvl), 1);
    int_ack = 1; int_ret = 1; tick(); int_ack = 0; int_ret = 0;
    chk("R12 ret then ack", 32'(svc_levels), 32'b0010);
    irq_src = '0; ret(); tick();

    // R4: global enable withdraws held request
    tag = "R4";
    irq_src = 9'b000100000; tick();
    chk("R4 req up", 32'(int_req), 1);
    set_gie(0); tick();
    chk("R4 withdrawn", 32'(int_req), 0);
    repeat (3) tick();
    chk("R4 blocked", 32'(int_req), 0);
    set_gie(1); tick();
    set_gie(0); int_ack = 1; tick(); int_ack = 0;
    chk("R4 ack wins", 32'(svc_levels), 32'b0001);
    irq_src = '0; ret(); set_gie(1);

    // R7: every vector
    tag = "R7";
    set_lo('0);
    for (int s = 0; s < 9; s++) begin
      irq_src = 9'(1 << s); tick();
      chk("R7 vector", 32'(int_vec), 32'(exp_vec(s)));
      ack(); irq_src = '0; ret();
    end

    // random mix
    tag = "R12 random";
    for (int c = 0; c < 4000; c++) begin
      irq_src = 9'($urandom) & 9'($urandom);
      int_ack = m_req && ($urandom % 3 == 0);
      int_ret = ($urandom % 10 == 0);
      if ($urandom % 25 == 0) begin
        int sel = $urandom % 7;
        cfg_we = 1;
        cfg_addr = (sel == 6) ? 4'd12 : 4'((sel / 2) * 4 + sel % 2);
        cfg_wdata = (sel == 6) ? 8'(($urandom % 8) != 0) : 8'($urandom);
      end
      tick();
      cfg_we = 0; int_ack = 0; int_ret = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule